// File: doc/BRIEF.md
# Fractured Dual-Output Lookup Slice

This block is a slice of four configurable logic elements, named A, B, C and D. Each element holds a 64-bit truth table split into two 32-entry halves. A 2:1 multiplexer joins the two halves. Element k is driven by six select inputs. Its low five selects index both halves at once.

The first output reads the lower half alone. The second output picks the upper or the lower half according to the sixth select. An element can therefore compute one arbitrary function of six inputs, using the second output only. It can also compute two arbitrary functions of the same five inputs. In that case the sixth select is tied high and both outputs are used. A 1-bit full adder fits in a single element this way: carry comes from the lower half and sum from the upper half.

The truth tables are loaded serially. While the configuration enable is high, one bit per clock moves through one shift chain that runs through all four elements. The outputs are purely combinational and always show the current table contents, including while a load is in progress.

Top module: `frac_lut_slice`

## Requirements
- R1: For element k, output `o5_o[k]` equals bit `i` of the element's table, where `i` is `sel_i[6k+4:6k]` (with `sel_i[6k]` as the LSB). Table bits 0..31 form the lower half.
- R2: `o6_o[k]` equals table bit `32+i` when `sel_i[6k+5]` is 1. It equals `o5_o[k]` when that bit is 0.
- R3: Each rising clock edge with `cfg_en_i` high shifts the 256-bit chain `{A,B,C,D}` left by one bit. Each element table counts bit 63 as its MSB. `cfg_din_i` enters D bit 0, and C bit 0 takes D bit 63 (likewise for B and A). `cfg_dout_o` shows A bit 63. A full load sends A's table MSB first, followed by B, C and D.
- R4: While `cfg_en_i` is low, no table bit changes, whatever `cfg_din_i` does.
- R5: While `rst_ni` is low, every table bit is cleared asynchronously. All outputs then read 0 until configuration is loaded.
- R6: The four elements evaluate independently. Element index k is 0 for A, 1 for B, 2 for C and 3 for D. Each element uses only its own select field and drives only output bit k.
- R7: Take a table whose lower half bit i holds the majority of `i[0]`, `i[1]` and `i[2]`, and whose upper half bit i holds `i[0]^i[1]^i[2]`. With `sel[5]=1`, that table yields carry-out on `o5_o` and sum on `o6_o` for inputs a=`sel[0]`, b=`sel[1]`, cin=`sel[2]`.
- R8: Evaluation is combinational: during a load, the outputs follow the partially shifted table in the cycle after each shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Asynchronous active-low reset, clears all tables |
| cfg_en_i | input | 1 | Shift enable for the configuration chain |
| cfg_din_i | input | 1 | Serial configuration data, enters element D |
| cfg_dout_o | output | 1 | Serial chain output, bit 63 of element A |
| sel_i | input | 24 | Six select inputs per element, element k at bits 6k+5..6k |
| o5_o | output | 4 | Lower-half output per element |
| o6_o | output | 4 | Six-input muxed output per element |

## Verification
Configuration shifting and combinational evaluation can act in the same cycle. The outputs read the table contents that the previous edge just changed. To provoke this, the bench clears the slice and shifts a single 1 into element D while its selects stay fixed. After each shift edge it reads `o5_o[3]`/`o6_o[3]` and judges them against the position the bit should have reached. Bulk checks also load pseudo-random tables and sweep all 64 select values per element against a model, and they repeat the sweep after toggling the serial input with the enable low.

// File: rtl/lut_pkg.sv
package lut_pkg;
  localparam int unsigned FA_SUB_W = 5;
  localparam int unsigned FA_TBL_W = 2 << FA_SUB_W;

  typedef enum logic [1:0] {ELEM_A, ELEM_B, ELEM_C, ELEM_D} elem_id_e;

  // Full-adder image: lower half = carry-out, upper half = sum.
  function automatic logic [FA_TBL_W-1:0] fa_table();
    logic [FA_TBL_W-1:0] t;
    t = '0;
    for (int i = 0; i < (1 << FA_SUB_W); i++) begin
      logic a, b, c;
      a = i[0];
      b = i[1];
      c = i[2];
      t[i]                    = (a & b) | (c & (a ^ b));
      t[i + (1 << FA_SUB_W)]  = a ^ b ^ c;
    end
    return t;
  endfunction
endpackage

// File: rtl/lut_sub_table.sv
module lut_sub_table #(
  parameter  int unsigned IDX_W = 5,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_en_i,
  input  logic             shift_in_i,
  output logic             shift_out_o,
  input  logic [IDX_W-1:0] idx_i,
  output logic             rd_o,
  output logic [DEPTH-1:0] bits_o
);
  logic [DEPTH-1:0] bits_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         bits_q <= '0;
    else if (shift_en_i) bits_q <= {bits_q[DEPTH-2:0], shift_in_i};
  end

  assign shift_out_o = bits_q[DEPTH-1];
  assign rd_o        = bits_q[idx_i];
  assign bits_o      = bits_q;
endmodule

// File: rtl/lut_frac_elem.sv
module lut_frac_elem #(
  parameter  int unsigned SUB_W = 5,
  localparam int unsigned SEL_W = SUB_W + 1,
  localparam int unsigned HALF  = 1 << SUB_W,
  localparam int unsigned TBL_W = 2 * HALF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_en_i,
  input  logic             cfg_din_i,
  output logic             cfg_dout_o,
  input  logic [SEL_W-1:0] sel_i,
  output logic             o5_o,
  output logic             o6_o,
  output logic [TBL_W-1:0] tbl_o
);
  logic [2:0]      link;
  logic [1:0]      rd;
  logic [HALF-1:0] half_bits [2];

  assign link[0] = cfg_din_i;

  // half 0 = lower table, half 1 = upper; chain runs lower -> upper
  for (genvar h = 0; h < 2; h++) begin : g_half
    lut_sub_table #(.IDX_W(SUB_W)) i_half (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .shift_en_i (cfg_en_i),
      .shift_in_i (link[h]),
      .shift_out_o(link[h+1]),
      .idx_i      (sel_i[SUB_W-1:0]),
      .rd_o       (rd[h]),
      .bits_o     (half_bits[h])
    );
  end

  assign cfg_dout_o = link[2];
  assign o5_o       = rd[0];
  assign o6_o       = sel_i[SUB_W] ? rd[1] : rd[0];
  assign tbl_o      = {half_bits[1], half_bits[0]};
endmodule

// File: rtl/frac_lut_slice.sv
module frac_lut_slice #(
  parameter  int unsigned N_ELEM = 4,
  parameter  int unsigned SUB_W  = 5,
  localparam int unsigned SEL_W  = SUB_W + 1,
  localparam int unsigned TBL_W  = 2 << SUB_W,
  localparam int unsigned FLAT_W = N_ELEM * TBL_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_en_i,
  input  logic                    cfg_din_i,
  output logic                    cfg_dout_o,
  input  logic [N_ELEM*SEL_W-1:0] sel_i,
  output logic [N_ELEM-1:0]       o5_o,
  output logic [N_ELEM-1:0]       o6_o
);
  logic [N_ELEM:0]     link;
  logic [FLAT_W-1:0]   tbl_flat;

  // serial data enters the last element (D) and leaves from element 0 (A)
  assign link[N_ELEM] = cfg_din_i;
  assign cfg_dout_o   = link[0];

  for (genvar k = 0; k < N_ELEM; k++) begin : g_elem
    logic [TBL_W-1:0] tbl;
    lut_frac_elem #(.SUB_W(SUB_W)) i_elem (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cfg_en_i  (cfg_en_i),
      .cfg_din_i (link[k+1]),
      .cfg_dout_o(link[k]),
      .sel_i     (sel_i[k*SEL_W +: SEL_W]),
      .o5_o      (o5_o[k]),
      .o6_o      (o6_o[k]),
      .tbl_o     (tbl)
    );
    // A occupies the top of the flat view so the chain is one left shift
    assign tbl_flat[(N_ELEM-1-k)*TBL_W +: TBL_W] = tbl;
  end
endmodule

// File: rtl/frac_lut_slice_chk.sv
module frac_lut_slice_chk #(
  parameter  int unsigned N_ELEM = 4,
  parameter  int unsigned SUB_W  = 5,
  localparam int unsigned SEL_W  = SUB_W + 1,
  localparam int unsigned FLAT_W = N_ELEM * (2 << SUB_W)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    cfg_en_i,
  input logic                    cfg_din_i,
  input logic [N_ELEM*SEL_W-1:0] sel_i,
  input logic [N_ELEM-1:0]       o5_o,
  input logic [N_ELEM-1:0]       o6_o,
  input logic [FLAT_W-1:0]       tbl_flat_i
);
  p_shift_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |=> tbl_flat_i == {$past(tbl_flat_i[FLAT_W-2:0]), $past(cfg_din_i)});

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_i |=> $stable(tbl_flat_i));

  p_rst_zero_r5: assert property (@(posedge clk_i)
    !rst_ni |-> (o5_o == '0 && o6_o == '0 && tbl_flat_i == '0));

  for (genvar k = 0; k < N_ELEM; k++) begin : g_chk
    p_o6_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sel_i[k*SEL_W + SUB_W] |-> o6_o[k] == o5_o[k]);
  end
endmodule

bind frac_lut_slice frac_lut_slice_chk #(.N_ELEM(N_ELEM), .SUB_W(SUB_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cfg_en_i  (cfg_en_i),
  .cfg_din_i (cfg_din_i),
  .sel_i     (sel_i),
  .o5_o      (o5_o),
  .o6_o      (o6_o),
  .tbl_flat_i(tbl_flat)
);

// File: tb/test_frac_lut_slice.sv
`timescale 1ns/1ps
module test_frac_lut_slice;
  localparam int N = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_en_i = 1'b0;
  logic          cfg_din_i = 1'b0;
  logic          cfg_dout_o;
  logic [N*6-1:0] sel_i = '0;
  logic [N-1:0]  o5_o, o6_o;

  int checks = 0;
  int fails  = 0;
  logic [63:0] tbl_m [N];

  localparam logic [63:0] SEEDS [4] = '{
    64'h9E37_79B9_7F4A_7C15, 64'hDEAD_BEEF_0123_4567,
    64'h0F0F_F0F0_3C3C_C3C3, 64'h8000_0000_0000_0001};

  always #4 clk_i = ~clk_i;

  frac_lut_slice i_frac_lut_slice (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_en_i(cfg_en_i), .cfg_din_i(cfg_din_i),
    .cfg_dout_o(cfg_dout_o), .sel_i(sel_i), .o5_o(o5_o), .o6_o(o6_o));

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] xs(input logic [63:0] x);
    logic [63:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 7);
    y = y ^ (y << 17);
    return y;
  endfunction

  // R3: A first, each MSB first
  task automatic load_all();
    for (int k = 0; k < N; k++)
      for (int b = 63; b >= 0; b--) begin
        @(negedge clk_i);
        cfg_en_i  = 1'b1;
        cfg_din_i = tbl_m[k][b];
      end
    @(negedge clk_i);
    cfg_en_i  = 1'b0;
    cfg_din_i = 1'b0;
  endtask

  task automatic sweep(input string req);
    for (int idx = 0; idx < 64; idx++) begin
      @(negedge clk_i);
      for (int k = 0; k < N; k++) sel_i[k*6 +: 6] = 6'((idx + k*17) & 63);
      #1;
      for (int k = 0; k < N; k++) begin
        logic [5:0] s;
        s = 6'((idx + k*17) & 63);
        chk({req, " R1 R6"}, o5_o[k], tbl_m[k][s[4:0]], $sformatf("o5 elem%0d sel=%0d", k, s));
        chk({req, " R2 R6"}, o6_o[k], s[5] ? tbl_m[k][32 + s[4:0]] : tbl_m[k][s[4:0]],
            $sformatf("o6 elem%0d sel=%0d", k, s));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // R5: reset state
    sel_i = '1;
    repeat (2) @(negedge clk_i);
    for (int k = 0; k < N; k++) begin
      chk("R5", o5_o[k], 1'b0, "o5 in reset");
      chk("R5", o6_o[k], 1'b0, "o6 in reset");
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R5", cfg_dout_o, 1'b0, "chain out after reset");

    // R8: evaluation during shifting, single 1 into element D
    sel_i = '0;
    cfg_en_i = 1'b1; cfg_din_i = 1'b1;
    @(negedge clk_i);
    chk("R8", o5_o[3], 1'b1, "D o5 sel0 after 1 shift");
    chk("R8", o6_o[3], 1'b1, "D o6 sel0 after 1 shift");
    chk("R8", o5_o[2], 1'b0, "C untouched");
    cfg_din_i = 1'b0;
    @(negedge clk_i);
    cfg_en_i = 1'b0;
    #1;
    chk("R8", o5_o[3], 1'b0, "D o5 sel0 after 2 shifts");
    sel_i[3*6 +: 6] = 6'd1;
    #1;
    chk("R8", o5_o[3], 1'b1, "D o5 sel1 after 2 shifts");
    sel_i[3*6 +: 6] = 6'd33;
    #1;
    chk("R8", o6_o[3], 1'b0, "D o6 sel33 upper still empty");

    // R1 R2 R3 R6: random tables from vector table
    for (int v = 0; v < 4; v++) begin
      logic [63:0] x;
      x = SEEDS[v];
      for (int k = 0; k < N; k++) begin
        x = xs(x);
        tbl_m[k] = x;
      end
      load_all();
      chk("R3", cfg_dout_o, tbl_m[0][63], "chain out = A msb");
      sweep($sformatf("vec%0d", v));
    end

    // R4: toggle serial input with enable low
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      cfg_din_i = i[0];
    end
    @(negedge clk_i);
    chk("R4", cfg_dout_o, tbl_m[0][63], "chain out held");
    sweep("R4 hold");

    // R7: full adder in element B, others zero
    for (int k = 0; k < N; k++) tbl_m[k] = '0;
    for (int i = 0; i < 32; i++) begin
      logic [4:0] ii;
      ii = 5'(i);
      tbl_m[1][i]      = (ii[0] & ii[1]) | (ii[2] & (ii[0] ^ ii[1]));
      tbl_m[1][32 + i] = ii[0] ^ ii[1] ^ ii[2];
    end
    load_all();
    for (int c = 0; c < 8; c++) begin
      logic [2:0] abc;
      int total;
      abc = 3'(c);
      total = int'(abc[0]) + int'(abc[1]) + int'(abc[2]);
      @(negedge clk_i);
      sel_i = '0;
      sel_i[6 +: 6] = {1'b1, 2'b00, abc};
      #1;
      chk("R7", o6_o[1], total[0], $sformatf("sum a,b,cin=%b", abc));
      chk("R7", o5_o[1], total[1], $sformatf("carry a,b,cin=%b", abc));
      chk("R6", o6_o[0], 1'b0, "A stays empty");
    end

    // R5: reset after configuration
    @(negedge clk_i);
    sel_i = '0;
    sel_i[6 +: 6] = 6'b100011;
    #1;
    chk("R7", o5_o[1], 1'b1, "carry before reset");
    rst_ni = 1'b0;
    #1;
    chk("R5", o5_o[1], 1'b0, "o5 cleared by reset");
    chk("R5", o6_o[1], 1'b0, "o6 cleared by reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R5", o5_o[1], 1'b0, "o5 zero after reset release");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule